// File: doc/BRIEF.md
# Probabilistic Adjacent-Row Refresher

This block sits beside a DRAM controller and guards against disturbance errors in rows next to a row that is opened often. The controller reports each row close, meaning a precharge that follows an activation, with its bank and row address. For every close the block takes a value from an on-chip pseudo-random generator and compares it with a programmable threshold. When the value is below the threshold, the block asks for one extra activation of a row next to the closed one. That activation refreshes the neighbour. Raising the threshold gives stronger protection at the cost of more refresh traffic, and a threshold near 0x0148 gives a chance of about one half percent per close. The block keeps no per-row counters.

The neighbour is the row above or the row below the closed one, and a second bit from the generator picks between them with equal chance. Row zero and the highest row each have only one neighbour, so the block always picks that one. The request waits in a single-entry slot until the controller accepts it. A request that finds the slot still occupied is discarded, and a saturating counter records it. The generator seed can be loaded at run time, so a test run can be repeated exactly.

Top module: `adjref_refresher`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `ref_valid` is 0 and `drop_cnt` is 0. The generator state after reset equals the parameter `RESET_SEED`.
- R2: The generator is a 32-bit shift register with next state `{s[30:0], s[31]^s[21]^s[1]^s[0]}`. It advances by exactly one step for each clock edge at which `close_valid` is 1 and `seed_load` is 0, and it holds otherwise.
- R3: A close event uses the current generator state. It produces a refresh only when `s[15:0]` is below `prob_thresh` as an unsigned number. A threshold of 0 never produces a refresh.
- R4: For a close row that is neither 0 nor the highest row, bit `s[16]` chooses the neighbour. A 1 selects row+1 and a 0 selects row−1.
- R5: A close of row 0 always requests row 1. A close of row 2^ROW_W−1 always requests row 2^ROW_W−2.
- R6: A refresh shows up on `ref_valid`, `ref_bank` and `ref_row` in the cycle after the clock edge that sampled the close. `ref_bank` equals the bank of the close.
- R7: While `ref_valid` is 1 and `ref_ready` is 0, the request and its bank and row stay unchanged.
- R8: The pending slot holds one request. A new refresh enters the slot if the slot is empty, or if the request already in it is accepted at the same edge.
- R9: A refresh that finds the slot full and not being accepted is dropped, and `drop_cnt` increments, saturating at all ones. Close events that do not produce a refresh never change `drop_cnt`.
- R10: When `seed_load` is 1, the generator state becomes `seed_value`, or 1 if `seed_value` is zero. A close presented in the same cycle is ignored. A seed load changes neither `drop_cnt` nor the pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_load | input | 1 | Load the generator state from `seed_value` |
| seed_value | input | 32 | Seed to load; zero is replaced by 1 |
| prob_thresh | input | 16 | Refresh threshold (probability × 65536) |
| close_valid | input | 1 | A row close is reported in this cycle |
| close_bank | input | BANK_W | Bank of the closed row |
| close_row | input | ROW_W | Closed row address |
| ref_valid | output | 1 | A neighbour refresh is pending |
| ref_ready | input | 1 | Controller accepts the pending refresh |
| ref_bank | output | BANK_W | Bank of the neighbour row |
| ref_row | output | ROW_W | Neighbour row to activate |
| drop_cnt | output | CNT_W | Saturating count of dropped refreshes |

## Verification
The hardest case to reach from the ports is a full drop counter. It takes tens of thousands of firing closes while the controller refuses requests. The stimulus holds `ref_ready` low with the threshold at its maximum for more than 65,536 consecutive closes, and then checks that the count stops at all ones. A second hard case is an exact match of the neighbour choice. It relies on a bench model of the generator that is fed the same close and seed-load history, including a zero seed and a seed load that coincides with a close. Directed closes at row 0 and at the top row cover both ends of the row range.

// File: rtl/adjref_pkg.sv
package adjref_pkg;

    localparam int RND_W   = 32;
    localparam int THR_W   = 16;
    localparam int DIR_BIT = THR_W;

    typedef logic [RND_W-1:0] rnd_t;
    typedef logic [THR_W-1:0] thr_t;

    typedef enum logic [1:0] {
        NB_DOWN  = 2'd0,
        NB_UP    = 2'd1,
        NB_FLOOR = 2'd2,
        NB_CEIL  = 2'd3
    } nb_kind_e;

    // one step of the maximal-length sequence, taps 32/22/2/1
    function automatic rnd_t rnd_advance(input rnd_t s);
        return {s[RND_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic rnd_t seed_fix(input rnd_t s);
        return (s == '0) ? rnd_t'(1) : s;
    endfunction

endpackage

// File: rtl/adjref_lfsr.sv
module adjref_lfsr
    import adjref_pkg::*;
#(
    parameter rnd_t INIT = 32'h1D2C_3B4A
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  rnd_t load_val,
    input  logic advance,
    output rnd_t state
);
    rnd_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= seed_fix(INIT);
        end else if (load) begin
            st_q <= seed_fix(load_val);
        end else if (advance) begin
            st_q <= rnd_advance(st_q);
        end
    end

    assign state = st_q;
endmodule

// File: rtl/adjref_pick.sv
module adjref_pick
    import adjref_pkg::*;
#(
    parameter int ROW_W = 16
) (
    input  rnd_t             rnd,
    input  thr_t             thresh,
    input  logic [ROW_W-1:0] row,
    output logic             fire,
    output logic [ROW_W-1:0] nb_row,
    output nb_kind_e         kind
);
    localparam logic [ROW_W-1:0] ROW_TOP = {ROW_W{1'b1}};

    always_comb begin
        fire = (rnd[THR_W-1:0] < thresh);
        if (row == '0) begin
            kind = NB_FLOOR;
        end else if (row == ROW_TOP) begin
            kind = NB_CEIL;
        end else if (rnd[DIR_BIT]) begin
            kind = NB_UP;
        end else begin
            kind = NB_DOWN;
        end
        unique case (kind)
            NB_FLOOR, NB_UP: nb_row = row + 1'b1;
            default:         nb_row = row - 1'b1;
        endcase
    end
endmodule

// File: rtl/adjref_slot.sv
module adjref_slot #(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [BANK_W-1:0] push_bank,
    input  logic [ROW_W-1:0]  push_row,
    input  logic              pop_ready,
    output logic              valid,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [CNT_W-1:0]  drops
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic              v;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
    } entry_t;

    entry_t           ent_q;
    logic [CNT_W-1:0] drop_q;
    logic             room;

    assign room = !ent_q.v || pop_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q  <= '0;
            drop_q <= '0;
        end else begin
            if (push && room) begin
                ent_q <= '{v: 1'b1, bank: push_bank, row: push_row};
            end else if (pop_ready) begin
                ent_q.v <= 1'b0;
            end
            if (push && !room && drop_q != CNT_MAX) begin
                drop_q <= drop_q + 1'b1;
            end
        end
    end

    assign valid = ent_q.v;
    assign bank  = ent_q.bank;
    assign row   = ent_q.row;
    assign drops = drop_q;
endmodule

// File: rtl/adjref_refresher.sv
module adjref_refresher
    import adjref_pkg::*;
#(
    parameter int   BANK_W     = 3,
    parameter int   ROW_W      = 16,
    parameter int   CNT_W      = 16,
    parameter rnd_t RESET_SEED = 32'h1D2C_3B4A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seed_load,
    input  logic [31:0]       seed_value,
    input  logic [15:0]       prob_thresh,
    input  logic              close_valid,
    input  logic [BANK_W-1:0] close_bank,
    input  logic [ROW_W-1:0]  close_row,
    output logic              ref_valid,
    input  logic              ref_ready,
    output logic [BANK_W-1:0] ref_bank,
    output logic [ROW_W-1:0]  ref_row,
    output logic [CNT_W-1:0]  drop_cnt
);
    rnd_t             lfsr_q;
    logic             evt;
    logic             fire;
    logic [ROW_W-1:0] nb_row;
    nb_kind_e         nb_kind;

    assign evt = close_valid && !seed_load;

    adjref_lfsr #(.INIT(RESET_SEED)) u_lfsr (
        .clk      (clk),
        .rst      (rst),
        .load     (seed_load),
        .load_val (seed_value),
        .advance  (evt),
        .state    (lfsr_q)
    );

    adjref_pick #(.ROW_W(ROW_W)) u_pick (
        .rnd    (lfsr_q),
        .thresh (prob_thresh),
        .row    (close_row),
        .fire   (fire),
        .nb_row (nb_row),
        .kind   (nb_kind)
    );

    adjref_slot #(.BANK_W(BANK_W), .ROW_W(ROW_W), .CNT_W(CNT_W)) u_slot (
        .clk       (clk),
        .rst       (rst),
        .push      (evt && fire),
        .push_bank (close_bank),
        .push_row  (nb_row),
        .pop_ready (ref_ready),
        .valid     (ref_valid),
        .bank      (ref_bank),
        .row       (ref_row),
        .drops     (drop_cnt)
    );
endmodule

// File: rtl/adjref_checker.sv
module adjref_checker #(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              seed_load,
    input logic [15:0]       prob_thresh,
    input logic              close_valid,
    input logic [BANK_W-1:0] close_bank,
    input logic [ROW_W-1:0]  close_row,
    input logic              ref_valid,
    input logic              ref_ready,
    input logic [BANK_W-1:0] ref_bank,
    input logic [ROW_W-1:0]  ref_row,
    input logic [CNT_W-1:0]  drop_cnt,
    input logic [31:0]       lfsr_q
);
    localparam logic [ROW_W-1:0] TOP = {ROW_W{1'b1}};

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        ref_valid && !ref_ready |=> ref_valid && $stable(ref_row) && $stable(ref_bank));

    a_r6_neighbour: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_valid) |-> ref_bank == $past(close_bank) &&
            (ref_row == ROW_W'($past(close_row) + 1'b1) ||
             ref_row == ROW_W'($past(close_row) - 1'b1)));

    a_r5_floor: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_valid) && $past(close_row) == '0 |-> ref_row == ROW_W'(1));

    a_r5_ceil: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_valid) && $past(close_row) == TOP |-> ref_row == TOP - 1'b1);

    a_r3_zero_thresh: assert property (@(posedge clk) disable iff (rst)
        !ref_valid && prob_thresh == '0 |=> !ref_valid);

    a_r9_monotone: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> drop_cnt >= $past(drop_cnt));

    a_r2_nonzero: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);

    a_r10_ignore: assert property (@(posedge clk) disable iff (rst)
        seed_load && !ref_valid |=> !ref_valid);
endmodule

bind adjref_refresher adjref_checker #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .CNT_W(CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .seed_load   (seed_load),
    .prob_thresh (prob_thresh),
    .close_valid (close_valid),
    .close_bank  (close_bank),
    .close_row   (close_row),
    .ref_valid   (ref_valid),
    .ref_ready   (ref_ready),
    .ref_bank    (ref_bank),
    .ref_row     (ref_row),
    .drop_cnt    (drop_cnt),
    .lfsr_q      (lfsr_q)
);

// File: tb/tb_adjref_refresher.sv
module tb_adjref_refresher;
    localparam int BANK_W = 3;
    localparam int ROW_W  = 16;
    localparam int CNT_W  = 16;
    localparam logic [31:0] RSEED = 32'h1D2C_3B4A;
    localparam logic [ROW_W-1:0] TOP = {ROW_W{1'b1}};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              seed_load = 1'b0;
    logic [31:0]       seed_value = '0;
    logic [15:0]       prob_thresh = '0;
    logic              close_valid = 1'b0;
    logic [BANK_W-1:0] close_bank = '0;
    logic [ROW_W-1:0]  close_row = '0;
    logic              ref_valid;
    logic              ref_ready = 1'b0;
    logic [BANK_W-1:0] ref_bank;
    logic [ROW_W-1:0]  ref_row;
    logic [CNT_W-1:0]  drop_cnt;

    always #2 clk = ~clk;

    adjref_refresher #(.BANK_W(BANK_W), .ROW_W(ROW_W), .CNT_W(CNT_W),
                       .RESET_SEED(RSEED)) dut (
        .clk(clk), .rst(rst), .seed_load(seed_load), .seed_value(seed_value),
        .prob_thresh(prob_thresh), .close_valid(close_valid),
        .close_bank(close_bank), .close_row(close_row), .ref_valid(ref_valid),
        .ref_ready(ref_ready), .ref_bank(ref_bank), .ref_row(ref_row),
        .drop_cnt(drop_cnt)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0]       m_st;
    logic              m_pv;
    logic [BANK_W-1:0] m_bank;
    logic [ROW_W-1:0]  m_row;
    logic [CNT_W-1:0]  m_drop;

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic logic [ROW_W-1:0] nb(input logic [ROW_W-1:0] r, input logic up);
        if (r == '0) return r + 1'b1;
        if (r == TOP) return r - 1'b1;
        return up ? r + 1'b1 : r - 1'b1;
    endfunction

    task automatic compare(input string tag);
        bit bad;
        n_chk++;
        bad = (ref_valid !== m_pv) || (drop_cnt !== m_drop) ||
              (m_pv && (ref_row !== m_row || ref_bank !== m_bank));
        if (bad) begin
            n_bad++;
            $display("FAIL %s: got v=%0b bank=%0d row=%h drops=%0d, expected v=%0b bank=%0d row=%h drops=%0d",
                     tag, ref_valid, ref_bank, ref_row, drop_cnt, m_pv, m_bank, m_row, m_drop);
        end
    endtask

    task automatic cyc(input logic cv, input logic [BANK_W-1:0] b, input logic [ROW_W-1:0] r,
                       input logic rdy, input logic sl, input logic [31:0] sd,
                       input logic [15:0] thr, input string tag);
        @(negedge clk);
        close_valid = cv; close_bank = b; close_row = r; ref_ready = rdy;
        seed_load = sl; seed_value = sd; prob_thresh = thr;
        if (m_pv && rdy) m_pv = 1'b0;
        if (sl) begin
            m_st = (sd == 0) ? 32'd1 : sd;
        end else if (cv) begin
            if (m_st[15:0] < thr) begin
                if (m_pv) begin
                    if (m_drop != {CNT_W{1'b1}}) m_drop = m_drop + 1'b1;
                end else begin
                    m_pv = 1'b1; m_bank = b; m_row = nb(r, m_st[16]);
                end
            end
            m_st = nxt(m_st);
        end
        @(posedge clk); #1;
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_st = RSEED; m_pv = 1'b0; m_bank = '0; m_row = '0; m_drop = '0;
        repeat (3) @(posedge clk);
        #1; compare("R1 during reset");
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1; compare("R1 after reset");

        // R3: zero threshold never fires
        for (int i = 0; i < 40; i++)
            cyc(1'b1, BANK_W'($urandom), ROW_W'($urandom), 1'($urandom), 1'b0, 0, 16'h0, "R3 zero threshold");

        // R8/R9: fill slot, then drops with ready low
        for (int i = 0; i < 8; i++)
            cyc(1'b1, 3'd5, ROW_W'(100 + i), 1'b0, 1'b0, 0, 16'hFFFF, "R9 drop while full");
        // R7: hold with ready low and no closes
        for (int i = 0; i < 4; i++)
            cyc(1'b0, 3'd0, 16'd0, 1'b0, 1'b0, 0, 16'hFFFF, "R7 hold");
        // R8: replace on same-edge accept
        for (int i = 0; i < 6; i++)
            cyc(1'b1, 3'd2, ROW_W'(5000 + i), 1'b1, 1'b0, 0, 16'hFFFF, "R8 accept and refill");
        cyc(1'b0, 3'd0, 16'd0, 1'b1, 1'b0, 0, 16'hFFFF, "R8 drain");

        // R5: edge rows
        for (int i = 0; i < 6; i++) begin
            cyc(1'b1, 3'd1, 16'd0, 1'b1, 1'b0, 0, 16'hFFFF, "R5 row zero");
            cyc(1'b1, 3'd6, TOP,   1'b1, 1'b0, 0, 16'hFFFF, "R5 top row");
        end

        // R10: zero seed, and seed load coinciding with a close
        cyc(1'b0, 3'd0, 16'd0, 1'b1, 1'b1, 32'h0, 16'hFFFF, "R10 zero seed");
        for (int i = 0; i < 20; i++)
            cyc(1'b1, 3'd3, ROW_W'(7000 + 3 * i), 1'b1, 1'b0, 0, 16'h8000, "R10 after zero seed");
        cyc(1'b1, 3'd4, 16'd9, 1'b1, 1'b1, 32'hCAFE_F00D, 16'hFFFF, "R10 close ignored");
        for (int i = 0; i < 20; i++)
            cyc(1'b1, 3'd4, ROW_W'(9 + i), 1'($urandom), 1'b0, 0, 16'h8000, "R10 reseeded sequence");

        // R2/R4/R6: random mix of thresholds and handshakes
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] th;
            int sel = $urandom_range(0, 2);
            th = (sel == 0) ? 16'h0148 : (sel == 1) ? 16'h8000 : 16'($urandom);
            cyc(1'($urandom_range(0, 3) != 0), BANK_W'($urandom), ROW_W'($urandom),
                1'($urandom_range(0, 2) != 0), 1'($urandom_range(0, 199) == 0),
                $urandom, th, "R2 R4 R6 random");
        end

        // R9: saturation of the drop counter
        for (int i = 0; i < 65600; i++)
            cyc(1'b1, 3'd7, 16'd1234, 1'b0, 1'b0, 0, 16'hFFFF, "R9 saturation");
        n_chk++;
        if (drop_cnt !== {CNT_W{1'b1}}) begin
            n_bad++;
            $display("FAIL R9 final count: got %0d, expected %0d", drop_cnt, {CNT_W{1'b1}});
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule